// File: doc/BRIEF.md
# Dual-Enable Static RAM Model

This block is a clocked, synthesizable stand-in for a byte-wide asynchronous static RAM. It has two chip selects of opposite polarity, an active-low output enable and an active-low write enable. On every clock edge the control pins are sampled. They are decoded into one of four modes: deselected, output disabled, read or write. A controller or a testbench can place the block where a board-level RAM would sit and drive it cycle by cycle.

A write lasts only while both selects are asserted and write enable is low. That overlap can be ended by any one of the three pins. The address and data seen on the last clock edge of the overlap are committed to the array on the edge where the overlap ends. Read data is registered, so it appears one clock after the read address is sampled. Output drive drops at once when the pins leave read mode. The bus is modelled as a separate data-out port and a drive-enable port. A two-bit mode code is also brought out for checking.

Top module: `dual_enable_sram`

## Requirements
- R1: The mode output follows the pins in the same cycle. It is 0 when `sel_n` is high or `sel` is low, whatever `oe_n` and `wr_n` are. Otherwise it is 3 when `wr_n` is low, 2 when `oe_n` is low, and 1 when both are high.
- R2: While deselected (mode 0), `dout_en` is low and `dout` is zero.
- R3: In output-disabled mode (mode 1), `dout_en` is low.
- R4: After a read-mode edge, if the pins are still in read mode, `dout_en` is high. `dout` then carries the byte stored at the address sampled on that edge.
- R5: While `wr_n` is low, `dout_en` is low, whatever `oe_n` is. This also holds when a select becomes active at or after the fall of `wr_n`.
- R6: A write commits the address and data of the last edge of the overlap. The overlap is `sel_n` low, `sel` high and `wr_n` low. Ending it by raising `wr_n`, by raising `sel_n` or by lowering `sel` gives the same result.
- R7: `wr_n` held low while deselected leaves the array unchanged.
- R8: `dout_en` falls in the same cycle that the pins leave read mode, with no clock edge needed.
- R9: A read sampled on the edge that commits a write to the same address returns the new byte.
- R10: Reset clears the output drive and any write in progress. It does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write enable |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data, zero when not driving |
| dout_en | output | 1 | Bus drive enable |
| mode | output | 2 | 0 deselected, 1 output disabled, 2 read, 3 write |

## Verification
The assertions assume that the control pins change only once per clock period and are stable at each sampling edge. The bench respects this by changing every pin at the falling edge and sampling just after the rising edge. The drive-enable checks also take for granted that any read-mode cycle counted as settled had reset released on the edge before. The stimulus therefore starts its first read only after several idle cycles. Addresses and data change only while no write overlap is open, so each commit has one well-defined address and byte.

// File: rtl/dual_enable_sram.sv
module dual_enable_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [1:0]        mode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] M_OFF = 2'd0, M_HIZ = 2'd1, M_RD = 2'd2, M_WR = 2'd3;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_q, rd_armed;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data, dout_q;

  wire selected   = !sel_n && sel;
  wire wr_overlap = selected && !wr_n;
  wire commit     = wr_q && !wr_overlap;
  wire fwd        = commit && (hold_addr == addr);

  assign mode    = !selected ? M_OFF : !wr_n ? M_WR : !oe_n ? M_RD : M_HIZ;
  assign dout_en = rd_armed && (mode == M_RD);
  assign dout    = dout_en ? dout_q : '0;

  always_ff @(posedge clk)
    if (commit) mem[hold_addr] <= hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      rd_armed  <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      dout_q    <= '0;
    end else begin
      wr_q     <= wr_overlap;
      rd_armed <= (mode == M_RD);
      if (wr_overlap) begin
        hold_addr <= addr;
        hold_data <= din;
      end
      if (mode == M_RD)
        dout_q <= fwd ? hold_data : mem[addr];
    end
  end
endmodule

module dual_enable_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       sel,
  input logic       wr_n,
  input logic       dout_en,
  input logic [1:0] mode
);
  a_r2_desel_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel) |-> !dout_en);
  a_r3_hiz_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> !dout_en);
  a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !dout_en);
  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd2 && $past(rst_n)) |-> dout_en);
  a_r1_write_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !wr_n) |-> (mode == 2'd3));
endmodule

bind dual_enable_sram dual_enable_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel),
  .wr_n(wr_n), .dout_en(dout_en), .mode(mode)
);

// File: tb/test_dual_enable_sram.sv
module test_dual_enable_sram;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic sel_n = 1, sel = 0, oe_n = 1, wr_n = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;
  logic [1:0] mode;
  int vectors = 0, miscompares = 0;

  always #5 clk = ~clk;

  dual_enable_sram #(.ADDR_W(AW), .DATA_W(DW)) i_dual_enable_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel),
    .oe_n(oe_n), .wr_n(wr_n), .din(din), .dout(dout), .dout_en(dout_en), .mode(mode));

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pins(input logic cn, input logic c, input logic o, input logic w);
    sel_n = cn; sel = c; oe_n = o; wr_n = w;
  endtask

  task automatic idle();
    @(negedge clk); pins(1, 0, 1, 1);
  endtask

  // style: 0 ends on wr_n, 1 on sel_n, 2 on sel
  task automatic wr(input int a, input logic [DW-1:0] d, input int style);
    @(negedge clk); addr = AW'(a); din = d; pins(0, 1, 1, 0);
    @(negedge clk);
    if (style == 0) wr_n = 1; else if (style == 1) sel_n = 1; else sel = 0;
    @(negedge clk); pins(1, 0, 1, 1);
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); addr = AW'(a); pins(0, 1, 0, 1);
    @(posedge clk); #2;
    chk({tag, " dout_en"}, int'(dout_en), 1);
    chk({tag, " dout"}, int'(dout), int'(exp));
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset mode", int'(mode), 0);
    chk("R10 reset dout_en", int'(dout_en), 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    // R1/R2/R3/R5: all 16 pin combinations on a scratch address
    addr = AW'(63); din = 8'hEE;
    for (int c = 0; c < 16; c++) begin
      int e;
      @(negedge clk); pins(c[3], c[2], c[1], c[0]);
      e = (c[3] || !c[2]) ? 0 : !c[0] ? 3 : !c[1] ? 2 : 1;
      #1 chk("R1 mode decode", int'(mode), e);
      @(posedge clk); #2;
      chk("R2 R3 R5 drive per mode", int'(dout_en), int'(e == 2));
      if (e == 0) chk("R2 dout zero", int'(dout), 0);
    end
    idle();

    // R6: fill array, rotating the pin that ends the write
    for (int a = 0; a < 63; a++) wr(a, pat(a), a % 3);
    for (int a = 0; a < 63; a++) rd(a, pat(a), "R4 R6 readback");
    idle();

    // R7: wr_n low while deselected, both ways
    @(negedge clk); addr = AW'(9); din = 8'h5A; pins(1, 1, 0, 0);
    @(negedge clk); pins(0, 0, 0, 0);
    @(negedge clk); pins(1, 0, 1, 1);
    rd(9, pat(9), "R7 deselected write ignored");

    // R5: select goes active after wr_n fell, oe_n low, bus stays off
    @(negedge clk); addr = AW'(12); din = 8'hC3; pins(1, 1, 0, 0);
    @(negedge clk); sel_n = 0;
    #1 chk("R5 late select mode", int'(mode), 3);
    @(posedge clk); #2 chk("R5 late select no drive", int'(dout_en), 0);
    @(negedge clk); wr_n = 1;
    @(posedge clk); #2;
    chk("R6 R9 late select commit read", int'(dout), 8'hC3);

    // R8: leaving read drops drive without a clock edge
    @(negedge clk); oe_n = 1;
    #1 chk("R8 drive off same cycle", int'(dout_en), 0);
    idle();

    // R9: read on the commit edge, same address
    @(negedge clk); addr = AW'(20); din = 8'h77; pins(0, 1, 1, 0);
    @(negedge clk); wr_n = 1; oe_n = 0;
    @(posedge clk); #2 chk("R9 forward on commit", int'(dout), 8'h77);
    idle();
    rd(20, 8'h77, "R9 stored after forward");

    // R10: reset mid-write does not commit, does not clear array
    @(negedge clk); addr = AW'(30); din = 8'h11; pins(0, 1, 1, 0);
    @(posedge clk); #2 rst_n = 0;
    @(negedge clk); pins(1, 0, 1, 1); rst_n = 1;
    repeat (2) @(negedge clk);
    rd(30, pat(30), "R10 array kept");
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule